// File: doc/BRIEF.md
# Three-Bit Group Odd-Parity Detector

This block watches a serial bit stream, one bit per qualified clock, and cuts it into back-to-back groups of three bits that never share a bit. When the third bit of a group arrives and the group, read in arrival order, is one of 001, 010, 100 or 111, the hit output is raised in that same cycle. Those four values are exactly the three-bit words with an odd number of ones. Cycles in which the valid qualifier is low are skipped: the group position and the partial group are kept, and no hit is produced.

The detector is a five-state Mealy machine. There is a start state and two states after the first bit, split by that bit's value. Two states after the second bit are named by the third-bit value that completes a match: 1 when the first two bits have even parity, 0 when they have odd parity. A parameter picks the state register. The default is a three-bit code in which the two first-bit states differ in one bit and the two second-bit states differ in one bit. The other choice is one flip-flop per state. Codes outside the legal set drive the hit low and go back to the start state on the next qualified clock.

Top module: `grp3_odd_detect`

## Requirements
- R1: A clock edge with rst_n low puts the machine in the start state, so the next qualified bit begins a new group. The hit output is 0 while rst_n is low, whatever the other inputs are.
- R2: hit is 1 only in a cycle where bit_vld is 1 and the presented bit is the third bit of a group, and the group's three bits in arrival order are 001, 010, 100 or 111 (odd parity). It is 0 for the other four groups.
- R3: Groups do not overlap. The qualified bit after a group's third bit is always the first bit of the next group.
- R4: While bit_vld is 0, hit is 0 and bit_in has no effect. The group position and the partial group are carried unchanged to the next qualified bit.
- R5: hit is a Mealy output. It reflects the third bit during the cycle that bit is presented, before the clock edge that samples it, and it falls after that edge.
- R6: With ENC_ONE_HOT = 0 the state register uses the codes start=000, first bit 0=100, first bit 1=101, need 1=110, need 0=111. With ENC_ONE_HOT = 1 exactly one of five flip-flops is set. Both settings give the same hit for every input sequence.
- R7: A reset in the middle of a group drops the partial group, and a reset with bit_vld high takes priority over the qualified bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifier; bit_in is taken only when high |
| hit | output | 1 | High while the third bit of an odd-parity group is presented |

## Verification
The assertions check on every cycle that the state register holds a legal code, or a single set bit in one-hot form. They also check that the state does not move while bit_vld is low, that a second-bit state always goes back to start on a qualified bit, and that hit only appears on a qualified third bit. Only the bench's scenarios can show the arrival-order mapping from each of the eight groups to hit, and that idle gaps of any placement leave the group intact. The bench scenarios also cover that a mid-group reset drops the partial group and that both encodings agree over a long stream.

// File: rtl/grp3_pkg.sv
// Package for the three-bit group detector.
// Holds the abstract state set and the code mapping for the binary register.
// Assumes: exactly five logical states; the binary code is three bits wide.
package grp3_pkg;

    localparam int NUM_ST  = 5;
    localparam int BIN_W   = 3;

    typedef enum logic [2:0] {
        ST_START = 3'd0,   // no bit of the group seen yet
        ST_B0    = 3'd1,   // first bit was 0
        ST_B1    = 3'd2,   // first bit was 1
        ST_NEED1 = 3'd3,   // two bits of even parity seen, a 1 completes a match
        ST_NEED0 = 3'd4    // two bits of odd parity seen, a 0 completes a match
    } grp_st_e;

    // Binary code of each logical state; codes are picked so that the
    // two first-bit states and the two second-bit states differ in one bit.
    function automatic logic [BIN_W-1:0] bin_code(input grp_st_e s);
        case (s)
            ST_START: bin_code = 3'b000;
            ST_B0:    bin_code = 3'b100;
            ST_B1:    bin_code = 3'b101;
            ST_NEED1: bin_code = 3'b110;
            ST_NEED0: bin_code = 3'b111;
            default:  bin_code = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/grp3_next.sv
// Next-state function of the group detector.
// Maps the decoded present state and the current bit to the state after a
// qualified clock. Assumes the caller applies the result only when the bit
// is qualified; an illegal present state always maps to the start state.
module grp3_next
    import grp3_pkg::*;
(
    input  grp_st_e cur_st,
    input  logic    cur_bad,
    input  logic    bit_in,
    output grp_st_e nxt_st
);

    // Transition table of the minimized machine.
    always_comb begin
        nxt_st = ST_START;
        if (!cur_bad) begin
            case (cur_st)
                ST_START: nxt_st = bit_in ? ST_B1 : ST_B0;
                ST_B0:    nxt_st = bit_in ? ST_NEED0 : ST_NEED1;
                ST_B1:    nxt_st = bit_in ? ST_NEED1 : ST_NEED0;
                ST_NEED1: nxt_st = ST_START;
                ST_NEED0: nxt_st = ST_START;
                default:  nxt_st = ST_START;
            endcase
        end
    end

endmodule

// File: rtl/grp3_state_reg.sv
// State register of the group detector, in one of two encodings.
// ENC_ONE_HOT = 0 keeps a three-bit adjacency code; ENC_ONE_HOT = 1 keeps one
// flip-flop per state. Decodes the stored value back to a logical state and
// flags any value outside the legal set. Assumes a synchronous active-low reset.
module grp3_state_reg
    import grp3_pkg::*;
#(
    parameter bit ENC_ONE_HOT = 1'b0,
    localparam int SW = ENC_ONE_HOT ? NUM_ST : BIN_W
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    adv,
    input  grp_st_e nxt_st,
    output grp_st_e cur_st,
    output logic    cur_bad
);

    logic [SW-1:0] st_q;
    logic [SW-1:0] st_d;
    logic [SW-1:0] st_rst;

    generate
        if (ENC_ONE_HOT) begin : g_onehot
            // Set only the flip-flop that belongs to the next state.
            always_comb begin
                st_d = '0;
                st_d[int'(nxt_st)] = 1'b1;
                st_rst = '0;
                st_rst[int'(ST_START)] = 1'b1;
            end

            // Decode: legal when exactly one flip-flop is set.
            always_comb begin
                cur_st  = ST_START;
                cur_bad = ($countones(st_q) != 1);
                for (int i = 0; i < NUM_ST; i++) begin
                    if (st_q[i]) cur_st = grp_st_e'(i);
                end
            end

            // R6: one-hot register never holds zero or several set bits
            p_onehot_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) || $past(rst_n) |-> $onehot(st_q));
        end else begin : g_binary
            // Look up the adjacency code of the next state.
            always_comb begin
                st_d   = bin_code(nxt_st);
                st_rst = bin_code(ST_START);
            end

            // Decode the three-bit code; the three unused codes are illegal.
            always_comb begin
                cur_bad = 1'b0;
                case (st_q)
                    3'b000:  cur_st = ST_START;
                    3'b100:  cur_st = ST_B0;
                    3'b101:  cur_st = ST_B1;
                    3'b110:  cur_st = ST_NEED1;
                    3'b111:  cur_st = ST_NEED0;
                    default: begin
                        cur_st  = ST_START;
                        cur_bad = 1'b1;
                    end
                endcase
            end

            // R6: binary register holds one of the five legal codes
            p_bin_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (st_q == 3'b000 || st_q[2]));
        end
    endgenerate

    // Hold the state unless a qualified bit arrives; reset wins.
    always_ff @(posedge clk) begin
        if (!rst_n)   st_q <= st_rst;
        else if (adv) st_q <= st_d;
    end

    // R4: no qualified bit, no state change
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(adv) |-> $stable(st_q));

    // R1: after a reset edge the register decodes to the start state
    p_reset_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cur_st == ST_START && !cur_bad));

endmodule

// File: rtl/grp3_hit.sv
// Mealy output stage of the group detector.
// Raises hit during a qualified third bit that completes an odd-parity group.
// Assumes the decoded state is valid only when cur_bad is low.
module grp3_hit
    import grp3_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  grp_st_e cur_st,
    input  logic    cur_bad,
    input  logic    bit_in,
    input  logic    bit_vld,
    output logic    hit
);

    logic want1;
    logic want0;

    // Which third-bit value completes a match in the present state.
    always_comb begin
        want1 = (cur_st == ST_NEED1) && !cur_bad;
        want0 = (cur_st == ST_NEED0) && !cur_bad;
    end

    // Combine with the current bit; gated by the qualifier and by reset.
    always_comb begin
        hit = rst_n && bit_vld && ((want1 && bit_in) || (want0 && !bit_in));
    end

    // R4: no hit on an unqualified cycle
    p_idle_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> !hit);

    // R2: hit only from a second-bit state
    p_hit_third_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cur_st == ST_NEED1 || cur_st == ST_NEED0));

    // R1: hit is silent during reset
    always_comb begin
        if (!rst_n) p_rst_quiet_r1: assert (!hit);
    end

endmodule

// File: rtl/grp3_odd_detect.sv
// Top of the three-bit group odd-parity detector.
// Reads one bit per qualified clock, groups bits in non-overlapping triples
// and flags the triples 001, 010, 100 and 111 with a Mealy output.
// Assumes synchronous inputs and a synchronous active-low reset.
module grp3_odd_detect
    import grp3_pkg::*;
#(
    parameter bit ENC_ONE_HOT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic hit
);

    grp_st_e cur_st;
    grp_st_e nxt_st;
    logic    cur_bad;

    grp3_next u_next (
        .cur_st (cur_st),
        .cur_bad(cur_bad),
        .bit_in (bit_in),
        .nxt_st (nxt_st)
    );

    grp3_state_reg #(.ENC_ONE_HOT(ENC_ONE_HOT)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (bit_vld),
        .nxt_st (nxt_st),
        .cur_st (cur_st),
        .cur_bad(cur_bad)
    );

    grp3_hit u_hit (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_st (cur_st),
        .cur_bad(cur_bad),
        .bit_in (bit_in),
        .bit_vld(bit_vld),
        .hit    (hit)
    );

    // R3: a qualified third bit always returns the machine to start
    p_group_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bit_vld) &&
        ($past(cur_st) == ST_NEED1 || $past(cur_st) == ST_NEED0) |-> cur_st == ST_START);

    // R3: a qualified bit from start always leaves start
    p_group_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bit_vld) && $past(cur_st) == ST_START && !$past(cur_bad)
        |-> (cur_st == ST_B0 || cur_st == ST_B1));

endmodule

// File: tb/tb_grp3_odd_detect.sv
// Bench: exhaustive sweep of all groups against all idle-gap placements,
// reset scenarios and a long pseudo-random stream, on both encodings.
module tb_grp3_odd_detect;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic hit;
    logic hit_oh;

    int n_cmp = 0;
    int n_bad = 0;
    int pos = 0;       // bench model: bits of the current group seen
    int par = 0;       // bench model: parity of those bits
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    grp3_odd_detect #(.ENC_ONE_HOT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld), .hit(hit));

    grp3_odd_detect #(.ENC_ONE_HOT(1'b1)) dut_oh (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld), .hit(hit_oh));

    task automatic check(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: hit=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Present one cycle, check the Mealy output before the edge, update model.
    task automatic step(input logic v, input logic b, input string req);
        logic exp;
        @(negedge clk);
        rst_n = 1'b1; bit_vld = v; bit_in = b;
        #(CLK_P/4);
        exp = v && (pos == 2) && ((par ^ int'(b)) == 1);
        check(hit, exp, req);
        check(hit_oh, exp, "R6");
        if (v) begin
            if (pos == 2) begin pos = 0; par = 0; end
            else begin pos++; par = par ^ int'(b); end
        end
    endtask

    task automatic do_reset(input logic v, input logic b);
        @(negedge clk);
        rst_n = 1'b0; bit_vld = v; bit_in = b;
        #(CLK_P/4);
        check(hit, 1'b0, "R1");
        check(hit_oh, 1'b0, "R1");
        pos = 0; par = 0;
    endtask

    initial begin
        logic [15:0] lfsr;
        do_reset(1'b0, 1'b0);
        do_reset(1'b0, 1'b0);

        // R2 R4: every group, every placement of idle gaps before its bits
        for (int g = 0; g < 8; g++) begin
            for (int gap = 0; gap < 8; gap++) begin
                for (int k = 2; k >= 0; k--) begin
                    if (gap[k]) step(1'b0, ~g[k], "R4");
                    step(1'b1, g[k], "R2");
                end
            end
        end

        // R5: hit falls after the edge that takes the third bit
        step(1'b1, 1'b0, "R5");
        step(1'b1, 1'b0, "R5");
        step(1'b1, 1'b1, "R5");   // 001, hit high now
        @(negedge clk); bit_vld = 1'b0; #(CLK_P/4);
        check(hit, 1'b0, "R5");

        // R3: stream 1 0 0 1 1 1 is two groups 100 and 111, no cross-group match
        step(1'b1, 1'b1, "R3"); step(1'b1, 1'b0, "R3"); step(1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, "R3"); step(1'b1, 1'b1, "R3"); step(1'b1, 1'b1, "R3");
        step(1'b1, 1'b0, "R3"); step(1'b1, 1'b1, "R3"); step(1'b1, 1'b1, "R3");

        // R7: reset after one and after two bits drops the partial group
        for (int part = 1; part <= 2; part++) begin
            for (int i = 0; i < part; i++) step(1'b1, 1'b1, "R7");
            do_reset(1'b0, 1'b0);
            step(1'b1, 1'b0, "R7"); step(1'b1, 1'b0, "R7"); step(1'b1, 1'b1, "R7");
        end

        // R7 R1: reset with a qualified bit that would have completed a match
        step(1'b1, 1'b0, "R7"); step(1'b1, 1'b0, "R7");
        do_reset(1'b1, 1'b1);
        step(1'b1, 1'b1, "R7"); step(1'b1, 1'b1, "R7"); step(1'b1, 1'b1, "R7");

        // R2 R4 R6: long pseudo-random stream with random qualifier
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3] | lfsr[7], lfsr[0], "R2");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule